// File: doc/BRIEF.md
# Tag-Chained DMA Source Sequencer

This block is the tag-decoding state machine of a chained DMA source channel. Each time the channel has fetched a 128-bit tag, the surrounding logic presents the tag's 3-bit identifier, its quadword count and its address field, and pulses a one-cycle strobe. On that strobe the sequencer computes and registers the new memory address (the start of the data packet) and the new tag address (where the next tag is read). It maintains a two-entry return-address stack for call and return tags, and it reports whether the chain finishes after the current packet.

The stack depth is kept as a 2-bit value that belongs in bits 5:4 of the channel control word. A configuration input decides whether call and return tags are honoured or ignored. A call made when the stack is already full ends the chain and sets a sticky overflow flag. A return made when the stack is empty ends the chain. Tag fetching, data movement and stall control are handled elsewhere.

Addresses are byte addresses. One quadword is 16 bytes, so a count of N advances an address by N×16. All arithmetic wraps modulo 2^ADDR_W. Reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `tagseq_top`

## Requirements
- R1: After reset, cur_madr, cur_tadr, ret_addr0, ret_addr1, stack_depth, chain_end and overflow_err are all zero.
- R2: Without a tag_valid strobe, every output keeps its value. All updates appear on the outputs in the cycle after the strobe.
- R3: Tag id 0 leaves cur_madr and cur_tadr unchanged and sets chain_end to 1.
- R4: Tag id 1 sets cur_madr to T+16 and cur_tadr to T+16+QWC×16, where T is the old cur_tadr. chain_end becomes 0.
- R5: Tag id 2 sets cur_madr to T+16 and cur_tadr to the tag's address field. chain_end becomes 0.
- R6: Tag ids 3 and 4 set cur_tadr to T+16 and leave cur_madr unchanged. chain_end becomes 0.
- R7: With the stack enabled, tag id 5 (call) behaves as follows when stack_depth is 0 or 1. It writes T+16+QWC×16 into ret_addr0 (if the depth was 0) or into ret_addr1 (if the depth was 1), and increments stack_depth. It sets cur_madr to T+16 and cur_tadr to the address field. chain_end becomes 0.
- R8: With the stack enabled, a call at stack_depth 2 sets cur_madr to T+16 and leaves cur_tadr and the stack unchanged. It sets chain_end to 1 and overflow_err to 1.
- R9: With the stack enabled, tag id 6 (return) at stack_depth 2 loads cur_tadr from ret_addr1 and clears ret_addr1. At stack_depth 1 it loads cur_tadr from ret_addr0 and clears ret_addr0. In both cases it decrements stack_depth, sets cur_madr to T+16, and sets chain_end to 0.
- R10: With the stack enabled, a return at stack_depth 0 sets cur_madr to T+16, leaves cur_tadr unchanged, and sets chain_end to 1.
- R11: Tag id 7 sets cur_madr to T+16, leaves cur_tadr unchanged, and sets chain_end to 1.
- R12: With stack_en low, tag ids 5 and 6 change no address or stack output and set chain_end to 0.
- R13: Once set, overflow_err stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tag_valid | input | 1 | One-cycle strobe: a decoded tag is present |
| tag_id | input | 3 | Tag identifier |
| tag_qwc | input | QWC_W | Quadword count of the packet |
| tag_addr | input | ADDR_W | Address field of the tag |
| stack_en | input | 1 | 1: call and return tags use the stack; 0: they are ignored |
| cur_madr | output | ADDR_W | Memory address register |
| cur_tadr | output | ADDR_W | Tag address register |
| ret_addr0 | output | ADDR_W | First return-address stack entry |
| ret_addr1 | output | ADDR_W | Second return-address stack entry |
| stack_depth | output | 2 | Stack depth (control word bits 5:4) |
| chain_end | output | 1 | The chain ends after the current packet |
| overflow_err | output | 1 | Sticky call-stack overflow flag |

## Verification
Some properties are checked by assertions on every cycle. These are:
- the stack depth never exceeds two;
- a push only happens with room on the stack, and a pop only happens from a non-empty stack;
- outputs hold when there is no strobe;
- an end tag always ends the chain without moving the tag address;
- the overflow flag is sticky and only rises together with a chain end.

The bench scenarios are what show the actual address arithmetic for each tag type: pushes landing in the right entry, pops restoring the right entry and clearing it, the ignored call and return tags when the stack is disabled, and the clearing of the sticky flag by a second reset.

// File: rtl/tagseq_pkg.sv
package tagseq_pkg;

  typedef enum logic [2:0] {
    TK_REF_END   = 3'd0,
    TK_COUNT     = 3'd1,
    TK_JUMP      = 3'd2,
    TK_REF       = 3'd3,
    TK_REF_STALL = 3'd4,
    TK_CALL      = 3'd5,
    TK_RETURN    = 3'd6,
    TK_FINISH    = 3'd7
  } tag_kind_e;

  localparam int STACK_ENTRIES = 2;
  localparam int DEPTH_W       = 2;
  localparam int QW_SHIFT      = 4;

endpackage

// File: rtl/tagseq_rst_sync.sv
module tagseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/tagseq_stack.sv
module tagseq_stack
  import tagseq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = STACK_ENTRIES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic               pop,
  input  logic [ADDR_W-1:0]  push_data,
  output logic [ADDR_W-1:0]  pop_data,
  output logic [DEPTH_W-1:0] depth,
  output logic               full,
  output logic               empty,
  output logic [ADDR_W-1:0]  entry0,
  output logic [ADDR_W-1:0]  entry1
);
  logic [DEPTH_W-1:0]        depth_q, depth_d;
  logic [ENTRIES*ADDR_W-1:0] ent_flat;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic              wr_en;
    logic [ADDR_W-1:0] val_q;
    assign wr_en = (push && depth_q == DEPTH_W'(i)) ||
                   (pop  && depth_q == DEPTH_W'(i + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     val_q <= '0;
      else if (wr_en) val_q <= push ? push_data : '0;
    end
    assign ent_flat[i*ADDR_W +: ADDR_W] = val_q;
  end

  always_comb begin
    pop_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (depth_q == DEPTH_W'(i + 1)) pop_data = ent_flat[i*ADDR_W +: ADDR_W];
    end
  end

  always_comb begin
    depth_d = depth_q;
    if (push)     depth_d = depth_q + DEPTH_W'(1);
    else if (pop) depth_d = depth_q - DEPTH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          depth_q <= '0;
    else if (push | pop) depth_q <= depth_d;
  end

  assign depth  = depth_q;
  assign full   = (depth_q >= DEPTH_W'(ENTRIES));
  assign empty  = (depth_q == '0);
  assign entry0 = ent_flat[0 +: ADDR_W];
  assign entry1 = ent_flat[ADDR_W +: ADDR_W];

  // R7
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (depth_q < DEPTH_W'(ENTRIES)));

  // R9
  pop_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (depth_q != '0));

  // R8
  depth_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEPTH_W'(ENTRIES));

  // R9
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/tagseq_next.sv
module tagseq_next
  import tagseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QWC_W  = 16
) (
  input  logic              fire,
  input  logic [2:0]        tag_id,
  input  logic [QWC_W-1:0]  tag_qwc,
  input  logic [ADDR_W-1:0] tag_addr,
  input  logic              stack_en,
  input  logic [ADDR_W-1:0] madr_q,
  input  logic [ADDR_W-1:0] tadr_q,
  input  logic              stk_full,
  input  logic              stk_empty,
  input  logic [ADDR_W-1:0] stk_top,
  output logic [ADDR_W-1:0] madr_d,
  output logic [ADDR_W-1:0] tadr_d,
  output logic              end_d,
  output logic              ovf_d,
  output logic              push,
  output logic              pop,
  output logic [ADDR_W-1:0] push_data
);
  localparam logic [ADDR_W-1:0] QW_BYTES = ADDR_W'(1) << QW_SHIFT;

  logic [ADDR_W-1:0] pkt_base;
  logic [ADDR_W-1:0] data_len;
  logic [ADDR_W-1:0] after_data;
  tag_kind_e         kind;

  assign kind       = tag_kind_e'(tag_id);
  assign pkt_base   = tadr_q + QW_BYTES;
  assign data_len   = ADDR_W'(tag_qwc) << QW_SHIFT;
  assign after_data = pkt_base + data_len;
  assign push_data  = after_data;

  always_comb begin
    madr_d = madr_q;
    tadr_d = tadr_q;
    end_d  = 1'b0;
    ovf_d  = 1'b0;
    push   = 1'b0;
    pop    = 1'b0;
    unique case (kind)
      TK_REF_END: end_d = 1'b1;
      TK_COUNT: begin
        madr_d = pkt_base;
        tadr_d = after_data;
      end
      TK_JUMP: begin
        madr_d = pkt_base;
        tadr_d = tag_addr;
      end
      TK_REF, TK_REF_STALL: tadr_d = pkt_base;
      TK_CALL: begin
        if (stack_en) begin
          madr_d = pkt_base;
          if (!stk_full) begin
            push   = fire;
            tadr_d = tag_addr;
          end else begin
            end_d = 1'b1;
            ovf_d = 1'b1;
          end
        end
      end
      TK_RETURN: begin
        if (stack_en) begin
          madr_d = pkt_base;
          if (!stk_empty) begin
            pop    = fire;
            tadr_d = stk_top;
          end else begin
            end_d = 1'b1;
          end
        end
      end
      TK_FINISH: begin
        madr_d = pkt_base;
        end_d  = 1'b1;
      end
      default: end_d = 1'b1;
    endcase
  end
endmodule

// File: rtl/tagseq_top.sv
module tagseq_top
  import tagseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QWC_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tag_valid,
  input  logic [2:0]         tag_id,
  input  logic [QWC_W-1:0]   tag_qwc,
  input  logic [ADDR_W-1:0]  tag_addr,
  input  logic               stack_en,
  output logic [ADDR_W-1:0]  cur_madr,
  output logic [ADDR_W-1:0]  cur_tadr,
  output logic [ADDR_W-1:0]  ret_addr0,
  output logic [ADDR_W-1:0]  ret_addr1,
  output logic [DEPTH_W-1:0] stack_depth,
  output logic               chain_end,
  output logic               overflow_err
);
  logic              rst_int_n;
  logic [ADDR_W-1:0] madr_q, tadr_q, madr_d, tadr_d;
  logic              end_q, end_d, err_q, ovf_d;
  logic              push, pop, stk_full, stk_empty;
  logic [ADDR_W-1:0] push_data, stk_top;

  tagseq_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  tagseq_next #(.ADDR_W(ADDR_W), .QWC_W(QWC_W)) u_next (
    .fire      (tag_valid),
    .tag_id    (tag_id),
    .tag_qwc   (tag_qwc),
    .tag_addr  (tag_addr),
    .stack_en  (stack_en),
    .madr_q    (madr_q),
    .tadr_q    (tadr_q),
    .stk_full  (stk_full),
    .stk_empty (stk_empty),
    .stk_top   (stk_top),
    .madr_d    (madr_d),
    .tadr_d    (tadr_d),
    .end_d     (end_d),
    .ovf_d     (ovf_d),
    .push      (push),
    .pop       (pop),
    .push_data (push_data)
  );

  tagseq_stack #(.ADDR_W(ADDR_W), .ENTRIES(STACK_ENTRIES)) u_stack (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (push),
    .pop       (pop),
    .push_data (push_data),
    .pop_data  (stk_top),
    .depth     (stack_depth),
    .full      (stk_full),
    .empty     (stk_empty),
    .entry0    (ret_addr0),
    .entry1    (ret_addr1)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      madr_q <= '0;
      tadr_q <= '0;
      end_q  <= 1'b0;
    end else if (tag_valid) begin
      madr_q <= madr_d;
      tadr_q <= tadr_d;
      end_q  <= end_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)                err_q <= 1'b0;
    else if (tag_valid && ovf_d)   err_q <= 1'b1;
  end

  assign cur_madr     = madr_q;
  assign cur_tadr     = tadr_q;
  assign chain_end    = end_q;
  assign overflow_err = err_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !tag_valid |=> ($stable(madr_q) && $stable(tadr_q) && $stable(end_q)));

  // R11
  finish_tag_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tag_valid && tag_id == 3'd7) |=> (end_q && $stable(tadr_q)));

  // R13
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    err_q |=> err_q);

  // R8
  ovf_ends_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(err_q) |-> end_q);
endmodule

// File: tb/tagseq_top_bench.sv
module tagseq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int QW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          tag_valid;
  logic [2:0]    tag_id;
  logic [QW-1:0] tag_qwc;
  logic [AW-1:0] tag_addr;
  logic          stack_en;
  logic [AW-1:0] cur_madr, cur_tadr, ret_addr0, ret_addr1;
  logic [1:0]    stack_depth;
  logic          chain_end, overflow_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [AW-1:0] m_madr, m_tadr, m_a0, m_a1;
  logic [1:0]    m_dep;
  logic          m_end, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  tagseq_top #(.ADDR_W(AW), .QWC_W(QW)) u_tagseq_top (
    .clk(clk), .rst_n(rst_n), .tag_valid(tag_valid), .tag_id(tag_id),
    .tag_qwc(tag_qwc), .tag_addr(tag_addr), .stack_en(stack_en),
    .cur_madr(cur_madr), .cur_tadr(cur_tadr), .ret_addr0(ret_addr0),
    .ret_addr1(ret_addr1), .stack_depth(stack_depth), .chain_end(chain_end),
    .overflow_err(overflow_err)
  );

  function automatic string req_of(logic [2:0] id, logic [1:0] dep, logic en);
    case (id)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3, 3'd4: return "R6";
      3'd5: return !en ? "R12" : (dep == 2'd2 ? "R8" : "R7");
      3'd6: return !en ? "R12" : (dep == 2'd0 ? "R10" : "R9");
      default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    m_madr = '0; m_tadr = '0; m_a0 = '0; m_a1 = '0;
    m_dep = '0; m_end = 0; m_err = 0;
  endtask

  task automatic model_step(logic [2:0] id, logic [QW-1:0] q, logic [AW-1:0] a, logic en);
    logic [AW-1:0] base, nxt;
    base = m_tadr + 32'd16;
    nxt  = base + ({16'd0, q} << 4);
    m_end = 0;
    case (id)
      3'd0: m_end = 1;
      3'd1: begin m_madr = base; m_tadr = nxt; end
      3'd2: begin m_madr = base; m_tadr = a; end
      3'd3, 3'd4: m_tadr = base;
      3'd5: if (en) begin
        m_madr = base;
        if (m_dep == 2'd0)      begin m_a0 = nxt; m_dep = 2'd1; m_tadr = a; end
        else if (m_dep == 2'd1) begin m_a1 = nxt; m_dep = 2'd2; m_tadr = a; end
        else begin m_end = 1; m_err = 1; end
      end
      3'd6: if (en) begin
        m_madr = base;
        if (m_dep == 2'd2)      begin m_tadr = m_a1; m_a1 = '0; m_dep = 2'd1; end
        else if (m_dep == 2'd1) begin m_tadr = m_a0; m_a0 = '0; m_dep = 2'd0; end
        else m_end = 1;
      end
      default: begin m_madr = base; m_end = 1; end
    endcase
  endtask

  task automatic cmp(string req, string fld, logic [AW-1:0] act, logic [AW-1:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, fld, act, exp);
    end
  endtask

  task automatic check_all(string req);
    n_chk++;
    cmp(req, "madr", cur_madr, m_madr);
    cmp(req, "tadr", cur_tadr, m_tadr);
    cmp(req, "asr0", ret_addr0, m_a0);
    cmp(req, "asr1", ret_addr1, m_a1);
    cmp(req, "depth", AW'(stack_depth), AW'(m_dep));
    cmp(req, "end", AW'(chain_end), AW'(m_end));
    cmp(req, (m_err || overflow_err) ? "err R13" : "err", AW'(overflow_err), AW'(m_err));
  endtask

  task automatic fire(logic [2:0] id, logic [QW-1:0] q, logic [AW-1:0] a, logic en);
    string r;
    @(negedge clk);
    tag_id = id; tag_qwc = q; tag_addr = a; stack_en = en; tag_valid = 1;
    r = req_of(id, m_dep, en);
    @(negedge clk);
    tag_valid = 0;
    model_step(id, q, a, en);
    check_all(r);
  endtask

  task automatic idle_check();
    @(negedge clk);
    tag_id = 3'($urandom); tag_addr = $urandom; stack_en = 1'($urandom);
    @(negedge clk);
    check_all("R2");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tag_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  initial begin
    rst_n = 0; tag_valid = 0; tag_id = '0; tag_qwc = '0; tag_addr = '0; stack_en = 1;
    void'($urandom(32'd20240611));
    do_reset();
    check_all("R1");
    fire(3'd2, 16'd0, 32'h0000_1000, 1);   // R5
    fire(3'd1, 16'd3, 32'hDEAD_BEEF, 1);   // R4
    fire(3'd3, 16'd5, 32'h0, 1);           // R6
    fire(3'd4, 16'd5, 32'h0, 1);           // R6
    fire(3'd6, 16'd2, 32'h0, 1);           // R10 empty return
    fire(3'd5, 16'd4, 32'h0000_8000, 1);   // R7 depth 0
    fire(3'd5, 16'd1, 32'h0000_9000, 1);   // R7 depth 1
    fire(3'd5, 16'd7, 32'h0000_A000, 1);   // R8 overflow
    idle_check();                          // R2
    fire(3'd5, 16'd7, 32'h0000_B000, 0);   // R12 call ignored
    fire(3'd6, 16'd7, 32'h0000_B000, 0);   // R12 return ignored
    fire(3'd6, 16'd0, 32'h0, 1);           // R9 depth 2
    fire(3'd6, 16'd0, 32'h0, 1);           // R9 depth 1
    fire(3'd0, 16'd9, 32'h1234_5678, 1);   // R3
    fire(3'd7, 16'd9, 32'h1234_5678, 1);   // R11
    fire(3'd1, 16'hFFFF, 32'h0, 1);        // R4 max count
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 8) == 0) idle_check();
      else fire(3'($urandom), 16'($urandom % 64), $urandom, ($urandom % 4) != 0);
    end
    do_reset();
    check_all("R13");                      // R13 flag cleared only by reset
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule